// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by Pattern-Address Bit 12

This block sits on a game cartridge between the picture processor's address bus and the CPU's interrupt line. It counts rendered scanlines without any timer of its own. When background tiles are fetched from the lower 4 KiB pattern area ($0000-$0FFF) and sprite tiles from the upper one ($1000-$1FFF), address bit 12 goes high once on each line, at the move from background fetches to sprite fetches. Sprite fetches happen on every line, even when no sprites are shown, so each line gives one rising edge.

A filter qualifies each rising edge of bit 12. Only a rise that follows a long enough low stretch counts. Each qualified edge steps an 8-bit down-counter. When the counter reaches zero and interrupts are unmasked, an active-low interrupt is raised. It stays low until software acknowledges it. Before the interrupt is due, software loads the line count through four write-only registers: reload value, reload request, disable with acknowledge, and enable.

Top module: `scanline_irq_counter`

## Requirements
- R1: After a synchronous reset, irq_n is high, the counter and the reload value are zero, no reload is pending and interrupts are masked.
- R2: A rising edge of ppu_a12 counts only if ppu_a12 was sampled low on at least LOW_MIN (default 3) consecutive clocks just before the rise. A shorter low stretch followed by a rise has no effect on the counter.
- R3: On a counted edge, the counter loads the reload value if it is zero or a reload is pending. Otherwise it decrements by one.
- R4: A write with reg_sel = 1 marks a reload as pending. The next counted edge consumes the pending reload and loads the reload value, whatever the current count is.
- R5: When the counter value after a counted edge is zero and interrupts are enabled, irq_n goes low on the second clock edge after ppu_a12 is first sampled high.
- R6: Once low, irq_n stays low through further counted edges and idle cycles until a write with reg_sel = 2.
- R7: A write with reg_sel = 2 releases irq_n and masks interrupts. While masked, reaching zero raises nothing, and a later unmask does not assert irq_n for a zero reached earlier.
- R8: A write with reg_sel = 3 unmasks interrupts, so the next zero result drives irq_n low.
- R9: A write with reg_sel = 0 stores cpu_wdata as the reload value. With a reload value of zero, every counted edge produces a zero result and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe, one clock per write |
| reg_sel | input | 2 | Register select: 0 reload value, 1 reload request, 2 disable/ack, 3 enable |
| cpu_wdata | input | 8 | Write data; used only for reg_sel 0 |
| ppu_a12 | input | 1 | Picture processor address bit 12, already synchronous to clk |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check that a qualified edge is a single-clock pulse that follows a low sample. They also check that the counter holds still without a counted edge, that a falling irq_n always traces back to a counted edge, and that an asserted interrupt holds until the disable register is written. Only the bench's scenarios can show the end-to-end behaviour. These include the exact number of lines to the interrupt for several reload values, the rejection of a two-clock low glitch, a reload request taking effect in mid-count, and a masked zero that stays silent after unmasking.

// File: rtl/scanline_irq_pkg.sv
// Package: shared register-select encoding and widths for the scanline
// interrupt counter. Assumes a 2-bit register select from the CPU decode.
package scanline_irq_pkg;
    typedef enum logic [1:0] {
        SEL_RELOAD_VAL = 2'd0,
        SEL_RELOAD_REQ = 2'd1,
        SEL_IRQ_OFF    = 2'd2,
        SEL_IRQ_ON     = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/a12_edge_filter.sv
// Module: a12_edge_filter
// Produces a one-clock pulse for each rise of address bit 12 that follows
// at least LOW_MIN consecutive low samples. Assumes the input is already
// synchronous to clk; it is registered once here to time the low run.
module a12_edge_filter #(
    parameter int LOW_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a12_i,
    output logic edge_o
);
    localparam int LW = $clog2(LOW_MIN + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

    logic          a12_s;
    logic [LW-1:0] low_run;

    // Sample the address bit; reset value high so no edge forms at start-up.
    always_ff @(posedge clk) begin
        if (!rst_n) a12_s <= 1'b1;
        else        a12_s <= a12_i;
    end

    // Count consecutive low samples, saturating at LOW_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_run <= '0;
        else if (a12_s)             low_run <= '0;
        else if (low_run < LOW_SAT) low_run <= low_run + 1'b1;
    end

    // A high sample after a long enough low run is a counted edge.
    always_comb edge_o = a12_s && (low_run >= LOW_SAT);

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
    // R2
    edge_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> !$past(a12_s));
endmodule

// File: rtl/line_count_core.sv
// Module: line_count_core
// Holds the reload value, the reload-pending flag and the down-counter.
// It steps the counter on each counted edge and flags a zero result.
// Assumes the write strobes are single-clock pulses.
module line_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             wr_val_i,
    input  logic             wr_req_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             zero_hit_o
);
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             reload_pend;

    // Next count for a counted edge: reload on zero or request, else step down.
    always_comb begin
        if (cnt == '0 || reload_pend) cnt_next = reload_val;
        else                          cnt_next = cnt - 1'b1;
    end

    // Store the reload value written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)        reload_val <= '0;
        else if (wr_val_i) reload_val <= wdata_i;
    end

    // Update the counter on counted edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (edge_i) cnt <= cnt_next;
    end

    // Keep the reload request until an edge uses it; a new request wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        reload_pend <= 1'b0;
        else if (wr_req_i) reload_pend <= 1'b1;
        else if (edge_i)   reload_pend <= 1'b0;
    end

    // Flag that this edge leaves the counter at zero.
    always_comb zero_hit_o = edge_i && (cnt_next == '0);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(cnt));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && cnt != '0 && !reload_pend) |=> cnt == $past(cnt) - 1'b1);
    // R4
    req_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && reload_pend) |=> cnt == $past(reload_val));
endmodule

// File: rtl/irq_latch.sv
// Module: irq_latch
// Holds the interrupt mask and the pending interrupt. A zero result sets
// the pending interrupt only while unmasked. The disable write clears
// both the mask and the pending interrupt, and takes priority.
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_hit_i,
    input  logic wr_off_i,
    input  logic wr_on_i,
    output logic irq_n_o
);
    logic irq_en;
    logic irq_pend;

    // Mask and pending state; disable wins over every other event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            irq_pend <= 1'b0;
        end else if (wr_off_i) begin
            irq_en   <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (wr_on_i)               irq_en   <= 1'b1;
            if (zero_hit_i && irq_en)  irq_pend <= 1'b1;
        end
    end

    // Drive the active-low request line.
    always_comb irq_n_o = !irq_pend;

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !wr_off_i) |=> !irq_n_o);
    // R7
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off_i |=> irq_n_o);
    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(zero_hit_i));
endmodule

// File: rtl/scanline_irq_counter.sv
// Module: scanline_irq_counter (top)
// Counts rendered lines from rises of address bit 12 and raises an
// active-low interrupt when the count reaches zero. Decodes the CPU
// register writes into single-purpose strobes. Assumes cpu_we is a
// one-clock pulse per write and ppu_a12 is synchronous to clk.
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int LOW_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] cpu_wdata,
    input  logic             ppu_a12,
    output logic             irq_n
);
    logic edge_q;
    logic zero_hit;
    logic wr_val, wr_req, wr_off, wr_on;

    // Decode the write strobe into one strobe per register.
    always_comb begin
        wr_val = cpu_we && (reg_sel == SEL_RELOAD_VAL);
        wr_req = cpu_we && (reg_sel == SEL_RELOAD_REQ);
        wr_off = cpu_we && (reg_sel == SEL_IRQ_OFF);
        wr_on  = cpu_we && (reg_sel == SEL_IRQ_ON);
    end

    a12_edge_filter #(.LOW_MIN(LOW_MIN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .a12_i  (ppu_a12),
        .edge_o (edge_q)
    );

    line_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_q),
        .wr_val_i   (wr_val),
        .wr_req_i   (wr_req),
        .wdata_i    (cpu_wdata),
        .zero_hit_o (zero_hit)
    );

    irq_latch u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_hit_i (zero_hit),
        .wr_off_i   (wr_off),
        .wr_on_i    (wr_on),
        .irq_n_o    (irq_n)
    );

    // R8
    on_no_instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_on && irq_n && !edge_q) |=> irq_n);
endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic       ppu_a12 = 1'b1;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scanline_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .reg_sel(reg_sel),
        .cpu_wdata(cpu_wdata), .ppu_a12(ppu_a12), .irq_n(irq_n)
    );

    // Reload values; irq expected after (value + 1) edges following a reload request.
    localparam logic [7:0] VEC [4] = '{8'd1, 8'd2, 8'd5, 8'd0};

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; reg_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // Hold A12 low for 'low' clocks, then high long enough for the irq to settle.
    task automatic line(input int low);
        @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (low) @(posedge clk);
        @(negedge clk);
        ppu_a12 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) line(4);
    endtask

    task automatic arm(input logic [7:0] v);
        wr(2'd0, v); wr(2'd1, 8'hA5); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", irq_n, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: with reload 0 and masked, edges do nothing visible
        lines(2);
        check("R1 masked after reset", irq_n, 1'b1);

        // Table walk: R3 R4 R5 R9
        for (int k = 0; k < 4; k++) begin
            arm(VEC[k]);
            lines(int'(VEC[k]));
            check("R3 high before zero", irq_n, 1'b1);
            line(4);
            check("R5 low at zero", irq_n, 1'b0);
            wr(2'd2, 8'h00);
            check("R7 ack releases", irq_n, 1'b1);
        end

        // R2: a two-clock low is rejected, three clocks counts
        arm(8'd1);
        line(4);                 // loads 1
        line(2);                 // ignored
        check("R2 short low ignored", irq_n, 1'b1);
        line(3);                 // 1 -> 0
        check("R2 three-clock low counts", irq_n, 1'b0);

        // R6: stays asserted over idle and more edges
        repeat (10) @(negedge clk);
        lines(3);
        check("R6 held until ack", irq_n, 1'b0);
        wr(2'd2, 8'h00);
        check("R7 ack", irq_n, 1'b1);

        // R4: reload request mid-count
        arm(8'd5);
        lines(3);                // 5, 4, 3
        wr(2'd0, 8'd1); wr(2'd1, 8'h00);
        line(4);                 // loads 1
        check("R4 mid-count reload", irq_n, 1'b1);
        line(4);                 // 0
        check("R4 zero after reload", irq_n, 1'b0);

        // R7: masked zero stays silent, unmask does not replay it
        arm(8'd1);
        wr(2'd2, 8'h00);
        lines(2);                // 1, 0 while masked
        check("R7 masked zero", irq_n, 1'b1);
        wr(2'd3, 8'h00);
        check("R7 no replay on unmask", irq_n, 1'b1);
        // R8: counter auto-reloads from zero; next zero now raises
        line(4);                 // 0 -> 1
        check("R8 auto reload", irq_n, 1'b1);
        line(4);                 // 0
        check("R8 unmasked zero", irq_n, 1'b0);

        // R1: reset in mid-operation clears the request
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears irq", irq_n, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog irq_n actual=%b expected=done", irq_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule